// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central bookkeeping for a small out-of-order machine that has no forwarding and no renaming. Decoded instructions arrive one at a time in program order, each naming an execution class, an operation code, a destination register and two source registers. The block assigns each accepted instruction to a free functional unit. It then walks that unit through four phases: issue, operand read, execute and result write. From its per-unit status table and its per-register pending-writer table it produces an issue-ready signal, a per-unit operand-read permit and a per-unit result-write permit.

The functional units themselves are outside the block. Each unit starts work when its read permit is seen and reports back with a one-cycle `fu_done` pulse whenever its latency has run out. The block never looks at data. It only decides when each step may happen, so that read-after-write, write-after-read and write-after-write orderings are kept through waiting alone.

With the default parameters the machine has four units, encoded as 3-bit tags with 0 meaning "no unit": tag 1 is the integer unit, tags 2 and 3 are the two multipliers, and tag 4 is the adder. There are 16 registers.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: After reset no unit is busy and no register has a pending writer. `in_ready` is 1 for any destination when the class is valid, and `rd_grant`, `wr_grant` and `issue_tag` are all 0.
- R2: The class codes are 0 integer, 1 multiply, 2 add and 3 none, and class 3 is never accepted. An instruction is accepted in the cycle where `in_valid` and `in_ready` are both 1, and `issue_tag` then shows the chosen unit (1 integer, 2 or 3 multiplier with the lower free one first, 4 adder). `in_ready` is 0 while no unit of the class is free, and a unit freed by a write becomes available in the following cycle.
- R3: `in_ready` is 0 while any accepted instruction that has not yet written its result has the same destination register as the presented instruction.
- R4: `rd_grant[u]` is 1 only while unit u waits to read and both of its sources are ready. A source with no pending writer at issue is ready at once, so the read comes in the cycle after issue. A source with a pending writer becomes ready only in the cycle after that writer's `wr_grant`, because nothing is forwarded.
- R5: After its read cycle, a unit is executing until `fu_done` for it is seen at a clock edge, and it requests a write from the next cycle. `fu_done` for a unit that is idle, waiting to read or waiting to write has no effect.
- R6: A unit that waits to write is not granted while another unit has not yet read a source that equals the waiting unit's destination and is already marked ready.
- R7: At most one `wr_grant` bit is set per cycle. Among the eligible units the lowest-numbered one wins, and `wr_reg` carries its destination register.
- R8: In the cycle after a write, every unit waiting on the writer's tag for a source sees that source as ready. The writer's register has no pending writer any more, and the writer is idle.
- R9: If an instruction is accepted in the same cycle in which the producer of one of its sources is granted its write, that source counts as ready at issue.
- R10: `fu_op` holds, in slice u (bits u*3 upward), the operation code of the instruction held by unit u while that unit is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A decoded instruction is presented |
| in_class | input | 2 | Execution class: 0 int, 1 mul, 2 add, 3 none |
| in_op | input | 3 | Operation code passed to the unit |
| in_dst | input | 4 | Destination register |
| in_src1 | input | 4 | First source register |
| in_src2 | input | 4 | Second source register |
| fu_done | input | 4 | Per-unit end-of-execution pulse, bit u for tag u+1 |
| in_ready | output | 1 | Presented instruction can be accepted this cycle |
| issue_tag | output | 3 | Tag of the unit accepting the instruction, 0 if none |
| rd_grant | output | 4 | Per-unit operand-read permit |
| wr_grant | output | 4 | Per-unit result-write permit, at most one set |
| wr_reg | output | 4 | Register written by the granted unit |
| fu_op | output | 12 | Operation code held by each unit |

## Verification
`in_ready` and `issue_tag` depend on the inputs in the same cycle. `rd_grant` and `wr_grant` come from registered state: a read is due at the earliest one cycle after issue or one cycle after the producer's write grant. A write is due at the earliest one cycle after the `fu_done` edge. The bench drives every input at the falling edge, compares all outputs one time unit later against a cycle model that it advances exactly once per clock, and releases `fu_done` only from that model's own count of execute cycles. Directed sequences set up RAW, WAW, WAR and structural stalls. Stray `fu_done` pulses and class 3 check that those inputs are ignored.

// File: rtl/sb_pkg.sv
// Shared types of the scoreboard hazard controller.
// Assumes: nothing beyond the encodings below, which the ports expose.
package sb_pkg;

    // Life-cycle phase of one functional-unit entry.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_EXEC  = 2'd2,
        PH_WRITE = 2'd3
    } sb_phase_t;

    // Execution class carried by an incoming instruction.
    typedef enum logic [1:0] {
        CL_INT  = 2'd0,
        CL_MUL  = 2'd1,
        CL_ADD  = 2'd2,
        CL_NONE = 2'd3
    } sb_class_t;

endpackage

// File: rtl/sb_issue_sel.sv
// Picks the functional unit for the presented instruction and decides
// whether it may issue. Unit 0 is integer, units 1..NUM_MUL are
// multipliers (lowest free wins), the last unit is the adder.
// Assumes: unit_busy comes from registers; dst_pending flags a WAW hazard.
module sb_issue_sel #(
    parameter int NUM_MUL = 2,
    parameter int NUM_FU  = NUM_MUL + 2,
    parameter int TAG_W   = 3
) (
    input  logic              in_valid,
    input  logic [1:0]        in_class,
    input  logic [NUM_FU-1:0] unit_busy,
    input  logic              dst_pending,
    output logic              in_ready,
    output logic [NUM_FU-1:0] iss_vec,
    output logic [TAG_W-1:0]  iss_tag
);
    import sb_pkg::*;

    logic [NUM_FU-1:0] cand;
    logic              found;

    // Candidate unit of the requested class (structural hazard check).
    always_comb begin
        cand  = '0;
        found = 1'b0;
        unique case (sb_class_t'(in_class))
            CL_INT: cand[0] = ~unit_busy[0];
            CL_MUL: begin
                for (int i = 1; i <= NUM_MUL; i++) begin
                    if (!found && !unit_busy[i]) begin
                        cand[i] = 1'b1;
                        found   = 1'b1;
                    end
                end
            end
            CL_ADD:  cand[NUM_FU-1] = ~unit_busy[NUM_FU-1];
            default: cand = '0;
        endcase
    end

    // Ready needs a free unit and no pending writer of the destination.
    always_comb begin
        in_ready = (|cand) && !dst_pending;
        iss_vec  = (in_valid && in_ready) ? cand : '0;
        iss_tag  = '0;
        for (int i = 0; i < NUM_FU; i++) begin
            if (iss_vec[i]) iss_tag = TAG_W'(i + 1);
        end
    end

endmodule

// File: rtl/sb_fu_entry.sv
// One row of the functional-unit status table: phase, operation,
// destination, sources, producer tags and ready flags. It moves
// READ -> EXEC when both sources are ready, EXEC -> WRITE on done, and
// WRITE -> IDLE when granted, and it snoops the write bus for wake-up.
// Assumes: iss_en only when idle; iss_q1/iss_q2 already exclude a
// producer that writes in the issue cycle.
module sb_fu_entry #(
    parameter int REG_W = 4,
    parameter int TAG_W = 3,
    parameter int OP_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_en,
    input  logic [OP_W-1:0]  iss_op,
    input  logic [REG_W-1:0] iss_dst,
    input  logic [REG_W-1:0] iss_s1,
    input  logic [REG_W-1:0] iss_s2,
    input  logic [TAG_W-1:0] iss_q1,
    input  logic [TAG_W-1:0] iss_q2,
    input  logic             done,
    input  logic [TAG_W-1:0] wb_tag,
    input  logic             wb_win,
    output logic             busy,
    output logic [OP_W-1:0]  op,
    output logic [REG_W-1:0] fi,
    output logic [REG_W-1:0] fj,
    output logic [REG_W-1:0] fk,
    output logic             rj,
    output logic             rk,
    output logic             rd_go,
    output logic             wr_req
);
    import sb_pkg::*;

    sb_phase_t        ph;
    logic [TAG_W-1:0] qj, qk;

    // Phase and field update for this unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= PH_IDLE;
            op <= '0;
            fi <= '0;
            fj <= '0;
            fk <= '0;
            qj <= '0;
            qk <= '0;
            rj <= 1'b0;
            rk <= 1'b0;
        end else if (iss_en) begin
            ph <= PH_READ;
            op <= iss_op;
            fi <= iss_dst;
            fj <= iss_s1;
            fk <= iss_s2;
            qj <= iss_q1;
            qk <= iss_q2;
            rj <= (iss_q1 == '0);
            rk <= (iss_q2 == '0);
        end else begin
            unique case (ph)
                PH_READ: begin
                    if (rj && rk) begin
                        ph <= PH_EXEC;
                        rj <= 1'b0;
                        rk <= 1'b0;
                    end else begin
                        if (qj != '0 && qj == wb_tag) begin
                            rj <= 1'b1;
                            qj <= '0;
                        end
                        if (qk != '0 && qk == wb_tag) begin
                            rk <= 1'b1;
                            qk <= '0;
                        end
                    end
                end
                PH_EXEC:  if (done) ph <= PH_WRITE;
                PH_WRITE: if (wb_win) ph <= PH_IDLE;
                default:  ph <= PH_IDLE;
            endcase
        end
    end

    // Status seen by the issue, read and write logic.
    always_comb begin
        busy   = (ph != PH_IDLE);
        rd_go  = (ph == PH_READ) && rj && rk;
        wr_req = (ph == PH_WRITE);
    end

endmodule

// File: rtl/sb_wb_arb.sv
// Result-write permission: a unit asking to write is held back while
// another unit has a ready, unread source equal to its destination (WAR).
// One write per cycle, lowest index first.
// Assumes: ready flags are cleared once a unit has read its operands.
module sb_wb_arb #(
    parameter int NUM_FU = 4,
    parameter int REG_W  = 4,
    parameter int TAG_W  = 3
) (
    input  logic [NUM_FU-1:0]            wr_req,
    input  logic [NUM_FU-1:0][REG_W-1:0] fi,
    input  logic [NUM_FU-1:0][REG_W-1:0] fj,
    input  logic [NUM_FU-1:0][REG_W-1:0] fk,
    input  logic [NUM_FU-1:0]            rj,
    input  logic [NUM_FU-1:0]            rk,
    output logic [NUM_FU-1:0]            wr_grant,
    output logic [TAG_W-1:0]             wb_tag,
    output logic [REG_W-1:0]             wb_reg
);
    logic [NUM_FU-1:0] war_block;
    logic [NUM_FU-1:0] elig;
    logic              found;

    // WAR detection per requesting unit.
    always_comb begin
        war_block = '0;
        for (int u = 0; u < NUM_FU; u++) begin
            for (int v = 0; v < NUM_FU; v++) begin
                if (v != u) begin
                    if ((fj[v] == fi[u] && rj[v]) || (fk[v] == fi[u] && rk[v]))
                        war_block[u] = 1'b1;
                end
            end
        end
        elig = wr_req & ~war_block;
    end

    // Fixed-priority pick of a single writer.
    always_comb begin
        wr_grant = '0;
        wb_tag   = '0;
        wb_reg   = '0;
        found    = 1'b0;
        for (int u = 0; u < NUM_FU; u++) begin
            if (elig[u] && !found) begin
                found       = 1'b1;
                wr_grant[u] = 1'b1;
                wb_tag      = TAG_W'(u + 1);
                wb_reg      = fi[u];
            end
        end
    end

endmodule

// File: rtl/sb_hazard_ctrl.sv
// Scoreboard hazard controller top. It holds the register pending-writer
// table, issues instructions in order (structural and WAW stalls), grants
// operand reads once RAW clears and grants result writes once WAR clears.
// Assumes: the functional units start on rd_grant and pulse fu_done once.
module sb_hazard_ctrl #(
    parameter int NUM_MUL = 2,
    parameter int NUM_REG = 16,
    parameter int OP_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [1:0]                    in_class,
    input  logic [OP_W-1:0]               in_op,
    input  logic [$clog2(NUM_REG)-1:0]    in_dst,
    input  logic [$clog2(NUM_REG)-1:0]    in_src1,
    input  logic [$clog2(NUM_REG)-1:0]    in_src2,
    input  logic [NUM_MUL+1:0]            fu_done,
    output logic                          in_ready,
    output logic [$clog2(NUM_MUL+3)-1:0]  issue_tag,
    output logic [NUM_MUL+1:0]            rd_grant,
    output logic [NUM_MUL+1:0]            wr_grant,
    output logic [$clog2(NUM_REG)-1:0]    wr_reg,
    output logic [(NUM_MUL+2)*OP_W-1:0]   fu_op
);
    localparam int NUM_FU = NUM_MUL + 2;
    localparam int REG_W  = $clog2(NUM_REG);
    localparam int TAG_W  = $clog2(NUM_FU + 1);

    logic [NUM_REG-1:0][TAG_W-1:0] res_tab;
    logic [NUM_FU-1:0]             unit_busy, rd_go, wr_req, rj, rk, iss_vec;
    logic [NUM_FU-1:0][REG_W-1:0]  fi, fj, fk;
    logic [NUM_FU-1:0][OP_W-1:0]   op_q;
    logic [TAG_W-1:0]              wb_tag, q1, q2, q1_raw, q2_raw;
    logic                          dst_pending;

    // Pending-writer lookups for the presented instruction.
    always_comb begin
        dst_pending = (res_tab[in_dst] != '0);
        q1_raw      = res_tab[in_src1];
        q2_raw      = res_tab[in_src2];
        q1          = (q1_raw == wb_tag) ? '0 : q1_raw;
        q2          = (q2_raw == wb_tag) ? '0 : q2_raw;
    end

    // Register result table: release on write, claim on issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_tab <= '0;
        end else begin
            if (wb_tag != '0) res_tab[wb_reg_int] <= '0;
            if (issue_tag != '0) res_tab[in_dst] <= issue_tag;
        end
    end

    logic [REG_W-1:0] wb_reg_int;

    sb_issue_sel #(
        .NUM_MUL (NUM_MUL),
        .NUM_FU  (NUM_FU),
        .TAG_W   (TAG_W)
    ) u_issue (
        .in_valid    (in_valid),
        .in_class    (in_class),
        .unit_busy   (unit_busy),
        .dst_pending (dst_pending),
        .in_ready    (in_ready),
        .iss_vec     (iss_vec),
        .iss_tag     (issue_tag)
    );

    for (genvar g = 0; g < NUM_FU; g++) begin : g_unit
        sb_fu_entry #(
            .REG_W (REG_W),
            .TAG_W (TAG_W),
            .OP_W  (OP_W)
        ) u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .iss_en  (iss_vec[g]),
            .iss_op  (in_op),
            .iss_dst (in_dst),
            .iss_s1  (in_src1),
            .iss_s2  (in_src2),
            .iss_q1  (q1),
            .iss_q2  (q2),
            .done    (fu_done[g]),
            .wb_tag  (wb_tag),
            .wb_win  (wr_grant[g]),
            .busy    (unit_busy[g]),
            .op      (op_q[g]),
            .fi      (fi[g]),
            .fj      (fj[g]),
            .fk      (fk[g]),
            .rj      (rj[g]),
            .rk      (rk[g]),
            .rd_go   (rd_go[g]),
            .wr_req  (wr_req[g])
        );
        // Per-unit outputs.
        assign fu_op[g*OP_W +: OP_W] = op_q[g];
        assign rd_grant[g]           = rd_go[g];
    end

    sb_wb_arb #(
        .NUM_FU (NUM_FU),
        .REG_W  (REG_W),
        .TAG_W  (TAG_W)
    ) u_arb (
        .wr_req   (wr_req),
        .fi       (fi),
        .fj       (fj),
        .fk       (fk),
        .rj       (rj),
        .rk       (rk),
        .wr_grant (wr_grant),
        .wb_tag   (wb_tag),
        .wb_reg   (wb_reg_int)
    );

    assign wr_reg = wb_reg_int;

endmodule

// File: rtl/sb_hazard_ctrl_chk.sv
// Port-level temporal checks of the scoreboard hazard controller,
// attached to every instance of the top by the bind at the end of file.
module sb_hazard_ctrl_chk #(
    parameter int NUM_MUL = 2,
    parameter int NUM_REG = 16,
    parameter int OP_W    = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         in_valid,
    input logic [$clog2(NUM_REG)-1:0]   in_dst,
    input logic                         in_ready,
    input logic [$clog2(NUM_MUL+3)-1:0] issue_tag,
    input logic [NUM_MUL+1:0]           rd_grant,
    input logic [NUM_MUL+1:0]           wr_grant
);
    localparam int NUM_FU = NUM_MUL + 2;

    // R7: a single result write per cycle.
    assert_one_writer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_grant));

    // R2: a unit is only assigned to a presented, accepted instruction.
    assert_issue_handshake_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_tag != '0) |-> (in_valid && in_ready));

    // R3: the same destination cannot issue again right behind its writer.
    assert_no_waw_followup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_tag != '0) |=> !((issue_tag != '0) && (in_dst == $past(in_dst))));

    for (genvar u = 0; u < NUM_FU; u++) begin : g_chk
        // R5: the read permit lasts one cycle, then the unit executes.
        assert_single_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[u] |=> !rd_grant[u]);
        // R8: a granted write frees the unit, so no repeated write grant.
        assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
            wr_grant[u] |=> !wr_grant[u]);
    end

endmodule

bind sb_hazard_ctrl sb_hazard_ctrl_chk #(
    .NUM_MUL (NUM_MUL),
    .NUM_REG (NUM_REG),
    .OP_W    (OP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_dst    (in_dst),
    .in_ready  (in_ready),
    .issue_tag (issue_tag),
    .rd_grant  (rd_grant),
    .wr_grant  (wr_grant)
);

// File: tb/sb_hazard_ctrl_bench.sv
// Bench: directed hazard cases plus seeded random traffic, compared every
// cycle against a cycle model built from the requirements.
module sb_hazard_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 4;
    localparam int NR = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_class = 2'd0;
    logic [2:0]  in_op = 3'd0;
    logic [3:0]  in_dst = 4'd0, in_src1 = 4'd0, in_src2 = 4'd0;
    logic [3:0]  fu_done = 4'd0;
    logic        in_ready;
    logic [2:0]  issue_tag;
    logic [3:0]  rd_grant, wr_grant, wr_reg;
    logic [11:0] fu_op;

    int n_chk = 0;
    int n_bad = 0;

    // model state: phase 0 idle, 1 read, 2 exec, 3 write
    int m_ph[NF], m_fi[NF], m_fj[NF], m_fk[NF], m_qj[NF], m_qk[NF], m_op[NF], m_cnt[NF];
    bit m_rj[NF], m_rk[NF];
    int m_res[NR];
    int lat_fix[NF];
    bit lat_rand = 1'b0;
    bit stray_en = 1'b1;

    sb_hazard_ctrl u_sb_hazard_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_op(in_op), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .fu_done(fu_done), .in_ready(in_ready), .issue_tag(issue_tag),
        .rd_grant(rd_grant), .wr_grant(wr_grant), .wr_reg(wr_reg), .fu_op(fu_op)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    function automatic bit war_hold(input int u);
        for (int v = 0; v < NF; v++) begin
            if (v != u && ((m_fj[v] == m_fi[u] && m_rj[v]) || (m_fk[v] == m_fi[u] && m_rk[v])))
                return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic int pick_unit(input int cls);
        if (cls == 0 && m_ph[0] == 0) return 0;
        if (cls == 1 && m_ph[1] == 0) return 1;
        if (cls == 1 && m_ph[2] == 0) return 2;
        if (cls == 2 && m_ph[3] == 0) return 3;
        return -1;
    endfunction

    task automatic model_reset();
        for (int u = 0; u < NF; u++) begin
            m_ph[u] = 0; m_fi[u] = 0; m_fj[u] = 0; m_fk[u] = 0; m_qj[u] = 0;
            m_qk[u] = 0; m_op[u] = 0; m_cnt[u] = 0; m_rj[u] = 0; m_rk[u] = 0;
            lat_fix[u] = 1;
        end
        for (int r = 0; r < NR; r++) m_res[r] = 0;
    endtask

    // One clock: drive at falling edge, compare, advance the model.
    task automatic step(input bit v, input int cls, input int op, input int dst,
                        input int s1, input int s2, output bit acc);
        logic [3:0] dn;
        int cand, etag, wwin, q1, q2;
        bit erdy;
        int erd;
        @(negedge clk);
        dn = '0;
        for (int u = 0; u < NF; u++) begin
            if (m_ph[u] == 2) begin
                if (m_cnt[u] == 0) dn[u] = 1'b1;
                else m_cnt[u]--;
            end else if (stray_en && $urandom_range(0, 11) == 0) begin
                dn[u] = 1'b1; // stray pulse must be ignored (R5)
            end
        end
        in_valid = v; in_class = cls[1:0]; in_op = op[2:0];
        in_dst = dst[3:0]; in_src1 = s1[3:0]; in_src2 = s2[3:0]; fu_done = dn;
        #1;
        cand = pick_unit(cls);
        erdy = (cand >= 0) && (m_res[dst] == 0);
        etag = (v && erdy) ? cand + 1 : 0;
        erd  = 0;
        for (int u = 0; u < NF; u++)
            if (m_ph[u] == 1 && m_rj[u] && m_rk[u]) erd |= (1 << u);
        wwin = -1;
        for (int u = 0; u < NF; u++)
            if (wwin < 0 && m_ph[u] == 3 && !war_hold(u)) wwin = u;
        check("R2 R3 in_ready", int'(in_ready), int'(erdy));
        check("R2 issue_tag", int'(issue_tag), etag);
        check("R4 R5 R8 R9 rd_grant", int'(rd_grant), erd);
        check("R6 R7 R8 wr_grant", int'(wr_grant), (wwin >= 0) ? (1 << wwin) : 0);
        if (wwin >= 0) check("R7 wr_reg", int'(wr_reg), m_fi[wwin]);
        for (int u = 0; u < NF; u++)
            if (m_ph[u] != 0) check("R10 fu_op", int'(fu_op[u*3 +: 3]), m_op[u]);
        // advance model
        for (int u = 0; u < NF; u++) begin
            if (erd[u]) begin
                m_ph[u] = 2; m_rj[u] = 0; m_rk[u] = 0;
                m_cnt[u] = lat_rand ? $urandom_range(0, 4) : lat_fix[u];
            end else if (m_ph[u] == 1 && wwin >= 0) begin
                if (m_qj[u] == wwin + 1) begin m_rj[u] = 1; m_qj[u] = 0; end
                if (m_qk[u] == wwin + 1) begin m_rk[u] = 1; m_qk[u] = 0; end
            end else if (m_ph[u] == 2 && dn[u]) begin
                m_ph[u] = 3;
            end
        end
        if (wwin >= 0) begin
            m_ph[wwin] = 0;
            m_res[m_fi[wwin]] = 0;
        end
        if (etag != 0) begin
            q1 = m_res[s1]; q2 = m_res[s2];
            m_ph[cand] = 1; m_op[cand] = op; m_fi[cand] = dst; m_fj[cand] = s1;
            m_fk[cand] = s2; m_qj[cand] = q1; m_qk[cand] = q2;
            m_rj[cand] = (q1 == 0); m_rk[cand] = (q2 == 0);
            m_res[dst] = cand + 1;
        end
        acc = (etag != 0);
    endtask

    task automatic issue(input int cls, input int op, input int dst, input int s1, input int s2);
        bit acc = 1'b0;
        int tries = 0;
        while (!acc && tries < 200) begin
            step(1'b1, cls, op, dst, s1, s2, acc);
            tries++;
        end
        if (!acc) check("R2 issue never accepted", 0, 1);
    endtask

    task automatic idle(input int n);
        bit acc;
        for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, 0, 0, acc);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit acc;
        int cls, op, dst, s1, s2;
        bit v;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: empty table after reset, every destination accepted
        for (int d = 0; d < NR; d++) begin
            @(negedge clk);
            in_valid = 1'b0; in_class = 2'd2; in_dst = d[3:0];
            #1;
            check("R1 in_ready after reset", int'(in_ready), 1);
            check("R1 rd_grant after reset", int'(rd_grant), 0);
            check("R1 wr_grant after reset", int'(wr_grant), 0);
            check("R1 issue_tag idle", int'(issue_tag), 0);
        end
        stray_en = 1'b0;
        // RAW: add waits for the multiplier result (R4, R8)
        lat_fix[1] = 5;
        issue(1, 3, 1, 2, 3);
        issue(2, 1, 4, 1, 5);
        idle(14);
        // WAW: second writer of r6 stalls until the first writes (R3)
        lat_fix[0] = 6;
        issue(0, 2, 6, 7, 8);
        issue(1, 4, 6, 9, 9);
        idle(14);
        // WAR: quick integer write of r11 held until the adder reads it (R6)
        lat_fix[1] = 8; lat_fix[0] = 0;
        issue(1, 5, 9, 2, 3);
        issue(2, 6, 10, 9, 11);
        issue(0, 7, 11, 0, 0);
        idle(20);
        // structural: third multiply waits for a free multiplier (R2)
        lat_fix[1] = 4; lat_fix[2] = 4;
        issue(1, 1, 12, 0, 0);
        issue(1, 2, 13, 0, 0);
        issue(1, 3, 14, 0, 0);
        idle(14);
        // class 3 never accepted (R2)
        for (int i = 0; i < 4; i++) step(1'b1, 3, 0, 5, 0, 0, acc);
        // same-cycle write and dependent issue arise in random traffic (R9)
        stray_en = 1'b1;
        lat_rand = 1'b1;
        cls = 1; op = 0; dst = 1; s1 = 2; s2 = 3;
        for (int i = 0; i < 3000; i++) begin
            v = ($urandom_range(0, 9) < 8);
            step(v, cls, op, dst, s1, s2, acc);
            if (acc || !v) begin
                cls = ($urandom_range(0, 19) == 0) ? 3 : $urandom_range(0, 2);
                op  = $urandom_range(0, 7);
                dst = $urandom_range(0, 7);
                s1  = $urandom_range(0, 7);
                s2  = $urandom_range(0, 7);
            end
        end
        idle(40);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule